// File: doc/BRIEF.md
# PAL Monochrome Raster Timing Generator

This block turns a 16 MHz clock into the timing of a monochrome PAL-style composite picture. It drives two outputs. The first is a sync line that a resistor network later mixes into the video level. The second is a serial pixel line. Pixel data comes from an external 1-bit-per-pixel frame buffer of 96 rows by 15 bytes. The block reads that buffer through a synchronous read port: it presents a byte address with a read strobe, and the data returns one clock later.

Two counters run inside the block. One counts clocks within a line and the other counts lines within a frame. Each line has one sync pulse, which starts at the line start and ends at a compare value. That compare value is short on ordinary lines and long on the closing lines of a frame. A window of lines is marked active. On those lines a row of the buffer is shifted out one pixel per four clocks. Every row is shown on two lines in a row: the read pointer steps back over the row after the first line of each pair. Every count and position is a parameter, so a bench can scale the geometry down.

Top module: `pal_raster_gen`

## Requirements
- R1: A line lasts LINE_CLKS clocks (default 1024) and a frame lasts FRAME_LINES lines (default 312). After the last clock of the last line, both counters return to zero and the pattern repeats.
- R2: Within a line, sync_o is low from clock 0 up to the compare value and high from the compare value to the end of the line.
- R3: The compare value is SHORT_CMP (default 75) on lines 0 to LONG_FIRST-1 (default 304) and LONG_CMP (default 942) on lines LONG_FIRST (default 305) to FRAME_LINES-1.
- R4: pixel_o is low on every line outside ACT_FIRST..ACT_LAST (defaults 54 and 245, inclusive) and whenever sync_o is low.
- R5: On an active line, pixel k (k from 0 to ROW_BYTES*8-1) is driven for CLK_PER_PIX clocks starting at clock PIX_START + k*CLK_PER_PIX (defaults 15 bytes, 4 clocks, 160). It is bit 7-(k mod 8) of byte k/8, so the most significant bit goes first. Outside that window pixel_o is low.
- R6: For byte b of an active line, rd_en_o is high for exactly one clock, at clock PIX_START + 32*b - 2 (the byte time is 8*CLK_PER_PIX clocks). rd_data_i is taken on the clock after the strobe. No strobe occurs on other clocks.
- R7: Active lines ACT_FIRST+2r and ACT_FIRST+2r+1 both read row r. Byte b of that row is read at address r*ROW_BYTES + b.
- R8: Every frame restarts reading at address 0, so each frame shows the same row addresses as the one before.
- R9: While rst_n is low, sync_o, pixel_o and rd_en_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (16 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_data_i | input | 8 | Frame buffer byte, valid the clock after rd_en_o |
| rd_en_o | output | 1 | Frame buffer read strobe |
| rd_addr_o | output | AW | Frame buffer byte address |
| sync_o | output | 1 | Composite sync level (low = sync tip) |
| pixel_o | output | 1 | Serial pixel (high = white) |

## Verification
The block is run through two full frames at a scaled-down geometry. The frame buffer model holds a byte pattern that depends on the address, so a wrong row, a wrong byte or a wrong bit order produces a different pixel. Probe windows are placed at several points. Line starts on short and long sync lines separate the two compare values. The first line and the second line of a pair separate correct rewinding from a pointer that runs on. The clocks around each byte boundary expose gaps, off-by-one fetch timing and a broken prefetch. Lines just outside the active window, and the first lines of the second frame, expose window and pointer-restart faults. A reset applied in the middle of a line checks that all outputs go quiet.

// File: rtl/pal_raster_pkg.sv
package pal_raster_pkg;
    localparam int DEF_LINE_CLKS   = 1024;
    localparam int DEF_FRAME_LINES = 312;
    localparam int DEF_SHORT_CMP   = 75;
    localparam int DEF_LONG_CMP    = 942;
    localparam int DEF_LONG_FIRST  = 305;
    localparam int DEF_ACT_FIRST   = 54;
    localparam int DEF_ACT_LAST    = 245;
    localparam int DEF_ROW_BYTES   = 15;
    localparam int DEF_CLK_PER_PIX = 4;
    localparam int DEF_PIX_START   = 160;
    // clocks between the read strobe and the first pixel of its byte
    localparam int FETCH_LEAD      = 2;
endpackage

// File: rtl/pal_line_timer.sv
module pal_line_timer import pal_raster_pkg::*; #(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int FRAME_LINES = DEF_FRAME_LINES,
    parameter int SHORT_CMP   = DEF_SHORT_CMP,
    parameter int LONG_CMP    = DEF_LONG_CMP,
    parameter int LONG_FIRST  = DEF_LONG_FIRST,
    parameter int ACT_FIRST   = DEF_ACT_FIRST,
    parameter int ACT_LAST    = DEF_ACT_LAST,
    localparam int HW = $clog2(LINE_CLKS),
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos_o,
    output logic          line_end_o,
    output logic          frame_end_o,
    output logic          sync_o,
    output logic          act_line_o,
    output logic          pair_second_o
);
    typedef struct packed {
        logic [HW-1:0] hpos;
        logic [VW-1:0] line;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [VW-1:0] line_rel;
    logic [HW-1:0] cmp_val;

    always_comb begin
        st_d        = st_q;
        line_end_o  = (st_q.hpos == HW'(LINE_CLKS - 1));
        frame_end_o = line_end_o && (st_q.line == VW'(FRAME_LINES - 1));
        st_d.hpos   = line_end_o ? '0 : st_q.hpos + 1'b1;
        if (frame_end_o)     st_d.line = '0;
        else if (line_end_o) st_d.line = st_q.line + 1'b1;

        cmp_val       = (st_q.line >= VW'(LONG_FIRST)) ? HW'(LONG_CMP) : HW'(SHORT_CMP);
        sync_o        = (st_q.hpos >= cmp_val);
        act_line_o    = (st_q.line >= VW'(ACT_FIRST)) && (st_q.line <= VW'(ACT_LAST));
        line_rel      = st_q.line - VW'(ACT_FIRST);
        pair_second_o = line_rel[0];
        hpos_o        = st_q.hpos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    hpos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hpos == HW'(LINE_CLKS - 1)) |=> (st_q.hpos == '0));
    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (st_q.line == '0));
    // R2
    sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (st_q.hpos == HW'(SHORT_CMP) || st_q.hpos == HW'(LONG_CMP)));
endmodule

// File: rtl/pal_pixel_fetch.sv
module pal_pixel_fetch import pal_raster_pkg::*; #(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int ROW_BYTES   = DEF_ROW_BYTES,
    parameter int CLK_PER_PIX = DEF_CLK_PER_PIX,
    parameter int PIX_START   = DEF_PIX_START,
    parameter int AW          = 11,
    localparam int HW      = $clog2(LINE_CLKS),
    localparam int BYTE_T  = 8 * CLK_PER_PIX,
    localparam int WIN_LEN = ROW_BYTES * BYTE_T
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos_i,
    input  logic          line_end_i,
    input  logic          frame_end_i,
    input  logic          act_line_i,
    input  logic          pair_second_i,
    input  logic [7:0]    rd_data_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          bit_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [7:0]    shreg;
        logic          load;
    } fch_t;

    fch_t st_d, st_q;
    int   rel_fetch, rel_pix;
    logic in_win;

    always_comb begin
        st_d      = st_q;
        rel_fetch = int'(hpos_i) + FETCH_LEAD - PIX_START;
        rel_pix   = int'(hpos_i) - PIX_START;
        in_win    = (rel_pix >= 0) && (rel_pix < WIN_LEN);
        rd_en_o   = act_line_i && (rel_fetch >= 0) && (rel_fetch < WIN_LEN)
                    && ((rel_fetch % BYTE_T) == 0);

        st_d.load = rd_en_o;
        if (st_q.load)
            st_d.shreg = rd_data_i;
        else if (in_win && ((rel_pix % CLK_PER_PIX) == CLK_PER_PIX - 1))
            st_d.shreg = {st_q.shreg[6:0], 1'b0};

        if (rd_en_o)
            st_d.ptr = st_q.ptr + 1'b1;
        else if (frame_end_i)
            st_d.ptr = '0;
        else if (line_end_i && act_line_i && !pair_second_i)
            st_d.ptr = st_q.ptr - AW'(ROW_BYTES);

        rd_addr_o = st_q.ptr;
        bit_o     = in_win && st_q.shreg[7];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);
    // R8
    ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (rd_addr_o == '0));
endmodule

// File: rtl/pal_raster_gen.sv
module pal_raster_gen import pal_raster_pkg::*; #(
    parameter int LINE_CLKS   = DEF_LINE_CLKS,
    parameter int FRAME_LINES = DEF_FRAME_LINES,
    parameter int SHORT_CMP   = DEF_SHORT_CMP,
    parameter int LONG_CMP    = DEF_LONG_CMP,
    parameter int LONG_FIRST  = DEF_LONG_FIRST,
    parameter int ACT_FIRST   = DEF_ACT_FIRST,
    parameter int ACT_LAST    = DEF_ACT_LAST,
    parameter int ROW_BYTES   = DEF_ROW_BYTES,
    parameter int CLK_PER_PIX = DEF_CLK_PER_PIX,
    parameter int PIX_START   = DEF_PIX_START,
    localparam int ROWS = (ACT_LAST - ACT_FIRST + 1) / 2,
    localparam int AW   = $clog2(ROWS * ROW_BYTES + 1),
    localparam int HW   = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    rd_data_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          sync_o,
    output logic          pixel_o
);
    logic [HW-1:0] hpos;
    logic          line_end, frame_end, act_line, pair_second, pix_bit;

    pal_line_timer #(
        .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
        .SHORT_CMP(SHORT_CMP), .LONG_CMP(LONG_CMP), .LONG_FIRST(LONG_FIRST),
        .ACT_FIRST(ACT_FIRST), .ACT_LAST(ACT_LAST)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .hpos_o(hpos), .line_end_o(line_end),
        .frame_end_o(frame_end), .sync_o(sync_o), .act_line_o(act_line),
        .pair_second_o(pair_second)
    );

    pal_pixel_fetch #(
        .LINE_CLKS(LINE_CLKS), .ROW_BYTES(ROW_BYTES), .CLK_PER_PIX(CLK_PER_PIX),
        .PIX_START(PIX_START), .AW(AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hpos_i(hpos), .line_end_i(line_end),
        .frame_end_i(frame_end), .act_line_i(act_line),
        .pair_second_i(pair_second), .rd_data_i(rd_data_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .bit_o(pix_bit)
    );

    assign pixel_o = pix_bit && act_line && sync_o;

    // R4
    pixel_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_o |-> (sync_o && act_line));
endmodule

// File: tb/pal_raster_gen_bench.sv
module pal_raster_gen_bench;
    localparam int CLK_PERIOD = 62;
    localparam int LC = 256, FL = 40, SC = 20, LCMP = 230, LF = 35;
    localparam int AF = 6, AL = 29, RB = 4, CPP = 4, PS = 40;
    localparam int BT = 8 * CPP;
    localparam int AW = $clog2(((AL - AF + 1) / 2) * RB + 1);
    localparam int NPROBE = 14;
    // frame, line, first clock, length, requirement number
    localparam int PROBES [NPROBE][5] = '{
        '{0, 2, 15, 10, 2}, '{0, 6, 36, 8, 6}, '{0, 6, 40, 130, 5},
        '{0, 7, 36, 134, 7}, '{0, 8, 36, 134, 7}, '{0, 29, 36, 134, 4},
        '{0, 30, 30, 150, 4}, '{0, 34, 15, 10, 3}, '{0, 35, 225, 10, 3},
        '{0, 39, 250, 6, 1}, '{1, 0, 0, 30, 1}, '{1, 6, 36, 134, 8},
        '{1, 7, 36, 134, 8}, '{1, 36, 225, 10, 3}
    };

    logic          clk = 0;
    logic          rst_n = 0;
    logic [7:0]    rd_data = 0;
    logic          rd_en, sync, pixel;
    logic [AW-1:0] rd_addr;
    int            checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pal_raster_gen #(
        .LINE_CLKS(LC), .FRAME_LINES(FL), .SHORT_CMP(SC), .LONG_CMP(LCMP),
        .LONG_FIRST(LF), .ACT_FIRST(AF), .ACT_LAST(AL), .ROW_BYTES(RB),
        .CLK_PER_PIX(CPP), .PIX_START(PS)
    ) u_pal_raster_gen (
        .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data), .rd_en_o(rd_en),
        .rd_addr_o(rd_addr), .sync_o(sync), .pixel_o(pixel)
    );

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 73 + 90) ^ (a >> 3));
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= mem_byte(int'(rd_addr));

    function automatic string rname(int r);
        case (r)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model at cycle t after reset release
    task automatic check_cycle(int t, string req);
        int  h = t % LC;
        int  v = (t / LC) % FL;
        int  cmp = (v >= LF) ? LCMP : SC;
        bit  act = (v >= AF) && (v <= AL);
        bit  es  = (h >= cmp);
        int  rp  = h - PS;
        int  rf  = h + 2 - PS;
        int  row = (v - AF) / 2;
        bit  ep  = 0;
        bit  er  = act && rf >= 0 && rf < RB * BT && (rf % BT) == 0;
        if (act && es && rp >= 0 && rp < RB * BT) begin
            logic [7:0] b = mem_byte(row * RB + (rp / CPP) / 8);
            ep = b[7 - ((rp / CPP) % 8)];
        end
        check(req, $sformatf("sync line %0d clk %0d", v, h), int'(sync), int'(es));
        check(req, $sformatf("pixel line %0d clk %0d", v, h), int'(pixel), int'(ep));
        check(req, $sformatf("rd_en line %0d clk %0d", v, h), int'(rd_en), int'(er));
        if (er)
            check(req, $sformatf("rd_addr line %0d clk %0d", v, h),
                  int'(rd_addr), row * RB + rf / BT);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t = 0;
        // R9: outputs quiet in reset
        repeat (4) begin
            @(negedge clk);
            check("R9", "sync in reset", int'(sync), 0);
            check("R9", "pixel in reset", int'(pixel), 0);
            check("R9", "rd_en in reset", int'(rd_en), 0);
        end
        rst_n = 1;
        check_cycle(0, "R1");
        for (int i = 0; i < NPROBE; i++) begin
            int start = (PROBES[i][0] * FL + PROBES[i][1]) * LC + PROBES[i][2];
            while (t < start - 1) begin
                @(negedge clk); t++;
                check_cycle(t, "R1");
            end
            for (int k = 0; k < PROBES[i][3]; k++) begin
                @(negedge clk); t++;
                check_cycle(t, rname(PROBES[i][4]));
            end
        end
        // reset mid-line during active pixels
        while ((t % LC) != PS + 5 || ((t / LC) % FL) != AF + 1) begin
            @(negedge clk); t++;
        end
        rst_n = 0;
        @(negedge clk);
        check("R9", "sync after mid-line reset", int'(sync), 0);
        check("R9", "pixel after mid-line reset", int'(pixel), 0);
        check("R9", "rd_en after mid-line reset", int'(rd_en), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule